// File: doc/BRIEF.md
# Byte FIFO Pair with Level-Triggered Interrupt Flags

This block holds the transmit and receive byte queues of a serial-peripheral controller. The host side pushes bytes toward the shifter, pulls received bytes back, and writes a control word that sets two watermark levels and can empty either queue. The shift engine on the other side takes transmit bytes from the head of one queue and deposits received bytes into the other.

Four sticky flags record a receive queue filled up to its watermark, a transmit queue drained down to its watermark, a receive byte lost to a full queue, and the end of a transfer. Each flag is cleared by writing a one to its position. A per-flag enable mask gates the flags onto one interrupt line. All host-visible words are plain registers, so a bus decoder only has to supply write strobes and route reads.

Top module: `spi_dual_fifo`

## Requirements
- R1: A host byte write (`tx_wr`) to a non-full transmit queue is stored in order. The engine sees the oldest byte on `eng_tx_data` while `eng_tx_valid` is 1, and `eng_tx_pop` removes it. The transmit count is in `occ_q[23:16]` and updates at the clock edge of the strobe.
- R2: An engine push (`eng_rx_push`) into a non-full receive queue is stored in order. The host sees the oldest byte on `rx_rdata`, and `rx_rd` removes it. The receive count is in `occ_q[7:0]` and updates at the edge of the strobe.
- R3: A receive push while the queue holds DEPTH bytes drops the byte, leaves the count at DEPTH, and sets overflow flag `sts_q[8]` at that edge.
- R4: A host transmit write while that queue holds DEPTH bytes is ignored. The count and the stored bytes are unchanged.
- R5: A control write `ctl_wdata` takes the receive level from bits [7:0] and the transmit level from bits [23:16]. A one in bit 15 empties the receive queue and a one in bit 31 empties the transmit queue, both at the edge of the write. These two bits read back as 1 in `ctl_q` for one cycle and then return to 0. The levels read back unchanged.
- R6: Flag `sts_q[0]` sets one clock edge after the receive count is at or above the receive level.
- R7: Flag `sts_q[4]` sets one clock edge after the transmit count is at or below the transmit level.
- R8: `sts_wr` clears each flag whose bit in `sts_wdata` is 1 and keeps the others, so writing all ones clears every flag. A level flag cleared while its condition still holds is 0 for one cycle and sets again at the next edge.
- R9: A one-cycle `xfer_done` pulse sets the completion flag `sts_q[12]` at that edge.
- R10: `ien_q` keeps only bits 0, 4, 8 and 12 of the last `ien_wdata` write; its other bits read 0. `irq` is 1 exactly when some flag and its enable bit are both 1.
- R11: When the overflow or completion event and a clear of the same flag arrive in one cycle, the flag ends up set.
- R12: While reset is asserted, all counts, flags, enables, levels and reset bits are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | Host strobe: push `tx_wdata` into transmit queue |
| tx_wdata | input | 8 | Host transmit byte |
| rx_rd | input | 1 | Host strobe: drop head of receive queue |
| rx_rdata | output | 8 | Head of receive queue |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: levels and queue-empty bits |
| ctl_q | output | 32 | Control word readback |
| ien_wr | input | 1 | Enable mask write strobe |
| ien_wdata | input | 32 | Enable mask data |
| ien_q | output | 32 | Enable mask readback |
| sts_wr | input | 1 | Flag clear strobe |
| sts_wdata | input | 32 | Ones clear the matching flags |
| sts_q | output | 32 | Flag readback |
| occ_q | output | 32 | Queue counts: receive [7:0], transmit [23:16] |
| xfer_done | input | 1 | Engine pulse at end of a transfer |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 8 | Transmit head byte |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
Counts, queue heads, overflow, completion and control readback all change at the clock edge of the strobe that causes them. The two level flags lag their count by one more edge, because they sample the registered count. `irq` follows the flag and enable registers with no added delay. The bench drives every input 5 ns after a rising edge and reads results in that same window after the edge of interest. For the level flags it checks once right after the count reaches the level, expecting 0, and once an edge later, expecting 1, so that an off-by-one latency is caught.

// File: rtl/spi_dual_fifo.sv
module spi_dual_fifo #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_wr,
  input  logic [7:0]  tx_wdata,
  input  logic        rx_rd,
  output logic [7:0]  rx_rdata,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_q,
  input  logic        ien_wr,
  input  logic [31:0] ien_wdata,
  output logic [31:0] ien_q,
  input  logic        sts_wr,
  input  logic [31:0] sts_wdata,
  output logic [31:0] sts_q,
  output logic [31:0] occ_q,
  input  logic        xfer_done,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  output logic        eng_tx_valid,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    rx_lvl, tx_lvl;
  logic          rx_flush, tx_flush;
  logic [3:0]    sts, en, clr;

  wire tx_clr  = ctl_wr & ctl_wdata[31];
  wire rx_clr  = ctl_wr & ctl_wdata[15];
  wire tx_full = tx_cnt == FULL;
  wire rx_full = rx_cnt == FULL;
  wire tx_push = tx_wr & ~tx_full;
  wire tx_pop  = eng_tx_pop & (tx_cnt != '0);
  wire rx_push = eng_rx_push & ~rx_full;
  wire rx_pop  = rx_rd & (rx_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wdata;
    if (rx_push) rx_mem[rx_wp] <= eng_rx_data;
  end

  assign eng_tx_data  = tx_mem[tx_rp];
  assign eng_tx_valid = tx_cnt != '0;
  assign rx_rdata     = rx_mem[rx_rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_lvl <= '0; tx_lvl <= '0; rx_flush <= 1'b0; tx_flush <= 1'b0; en <= '0;
    end else begin
      rx_flush <= rx_clr;
      tx_flush <= tx_clr;
      if (ctl_wr) begin
        rx_lvl <= ctl_wdata[7:0];
        tx_lvl <= ctl_wdata[23:16];
      end
      if (ien_wr) en <= {ien_wdata[12], ien_wdata[8], ien_wdata[4], ien_wdata[0]};
    end
  end

  assign clr = sts_wr ? {sts_wdata[12], sts_wdata[8], sts_wdata[4], sts_wdata[0]} : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else begin
      sts[0] <= clr[0] ? 1'b0 : sts[0] | (9'(rx_cnt) >= 9'(rx_lvl));
      sts[1] <= clr[1] ? 1'b0 : sts[1] | (9'(tx_cnt) <= 9'(tx_lvl));
      sts[2] <= (sts[2] & ~clr[2]) | (eng_rx_push & rx_full);
      sts[3] <= (sts[3] & ~clr[3]) | xfer_done;
    end
  end

  always_comb begin
    sts_q = '0;
    ien_q = '0;
    {sts_q[12], sts_q[8], sts_q[4], sts_q[0]} = sts;
    {ien_q[12], ien_q[8], ien_q[4], ien_q[0]} = en;
  end

  assign ctl_q = {tx_flush, 7'b0, tx_lvl, rx_flush, 7'b0, rx_lvl};
  assign occ_q = {8'b0, 8'(tx_cnt), 8'b0, 8'(rx_cnt)};
  assign irq   = |(sts & en);
endmodule

// File: rtl/spi_dual_fifo_chk.sv
module spi_dual_fifo_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_wr,
  input logic        ctl_wr,
  input logic [31:0] ctl_wdata,
  input logic [31:0] ctl_q,
  input logic [31:0] ien_q,
  input logic [31:0] sts_q,
  input logic [31:0] occ_q,
  input logic        xfer_done,
  input logic        eng_tx_pop,
  input logic        eng_rx_push,
  input logic        irq
);
  localparam logic [7:0] FULL = 8'(DEPTH);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && occ_q[7:0] == FULL) |=> sts_q[8]);

  p_rx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q[7:0] <= FULL);

  p_tx_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !eng_tx_pop && !ctl_wr && occ_q[23:16] == FULL) |=> occ_q[23:16] == FULL);

  p_flush_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[15] && !ctl_wr) |=> !ctl_q[15]);

  p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[31]) |=> occ_q[23:16] == 8'd0);

  p_done_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> sts_q[12]);

  p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[12] && ien_q[12]) |-> irq);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 32'd0) |-> !irq);
endmodule

bind spi_dual_fifo spi_dual_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_q(ctl_q), .ien_q(ien_q), .sts_q(sts_q), .occ_q(occ_q), .xfer_done(xfer_done),
  .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .irq(irq)
);

// File: tb/test_spi_dual_fifo.sv
module test_spi_dual_fifo;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_wr = 0, rx_rd = 0, ctl_wr = 0, ien_wr = 0, sts_wr = 0;
  logic xfer_done = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0] tx_wdata = 0, eng_rx_data = 0;
  logic [31:0] ctl_wdata = 0, ien_wdata = 0, sts_wdata = 0;
  logic [7:0] rx_rdata, eng_tx_data;
  logic [31:0] ctl_q, ien_q, sts_q, occ_q;
  logic eng_tx_valid, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  spi_dual_fifo #(.DEPTH(DEPTH)) i_spi_dual_fifo (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata), .ien_q(ien_q), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .sts_q(sts_q), .occ_q(occ_q), .xfer_done(xfer_done),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .irq(irq)
  );

  // op: 0 host tx write, 1 engine tx pop, 2 engine rx push, 3 host rx read
  localparam logic [25:0] TBL [12] = '{
    {2'd0, 8'hA5, 8'd1, 8'd0}, {2'd0, 8'h3C, 8'd2, 8'd0}, {2'd0, 8'h7E, 8'd3, 8'd0},
    {2'd1, 8'hA5, 8'd2, 8'd0}, {2'd2, 8'h11, 8'd2, 8'd1}, {2'd2, 8'h22, 8'd2, 8'd2},
    {2'd2, 8'h33, 8'd2, 8'd3}, {2'd3, 8'h11, 8'd2, 8'd2}, {2'd1, 8'h3C, 8'd1, 8'd2},
    {2'd1, 8'h7E, 8'd0, 8'd2}, {2'd3, 8'h22, 8'd0, 8'd1}, {2'd3, 8'h33, 8'd0, 8'd0}
  };

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    tx_wr = 0; rx_rd = 0; ctl_wr = 0; ien_wr = 0; sts_wr = 0;
    xfer_done = 0; eng_tx_pop = 0; eng_rx_push = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R12 occ", occ_q, 0);
    chk("R12 sts", sts_q, 0);
    chk("R12 ien", ien_q, 0);
    chk("R12 ctl", ctl_q, 0);
    chk("R12 irq", {31'd0, irq}, 0);
    rst_n = 1;
    tick();
    chk("R6 R7 level zero flags", sts_q, 32'h11);

    ctl_wr = 1; ctl_wdata = 32'h0002_0003;
    tick(); idle();
    chk("R5 levels", ctl_q, 32'h0002_0003);

    foreach (TBL[i]) begin
      case (TBL[i][25:24])
        2'd0: begin tx_wr = 1; tx_wdata = TBL[i][23:16]; end
        2'd1: begin chk("R1 tx head", {24'd0, eng_tx_data}, {24'd0, TBL[i][23:16]}); eng_tx_pop = 1; end
        2'd2: begin eng_rx_push = 1; eng_rx_data = TBL[i][23:16]; end
        default: begin chk("R2 rx head", {24'd0, rx_rdata}, {24'd0, TBL[i][23:16]}); rx_rd = 1; end
      endcase
      tick(); idle();
      chk("R1 tx count", {24'd0, occ_q[23:16]}, {24'd0, TBL[i][15:8]});
      chk("R2 rx count", {24'd0, occ_q[7:0]}, {24'd0, TBL[i][7:0]});
    end

    sts_wr = 1; sts_wdata = 32'hFFFF_FFFF;
    tick(); idle();
    chk("R8 clear all", sts_q, 0);
    tick();
    chk("R8 level flag sets again", {31'd0, sts_q[4]}, 1);
    for (int k = 1; k <= 3; k++) begin
      eng_rx_push = 1; eng_rx_data = 8'(k);
      tick(); idle();
    end
    chk("R6 not yet", {31'd0, sts_q[0]}, 0);
    tick();
    chk("R6 rx ready", {31'd0, sts_q[0]}, 1);

    ctl_wr = 1; ctl_wdata = 32'h8002_8003;
    tick(); idle();
    chk("R5 flush counts", occ_q, 0);
    chk("R5 flush bits visible", ctl_q, 32'h8002_8003);
    tick();
    chk("R5 flush bits self clear", ctl_q, 32'h0002_0003);

    for (int k = 0; k < 4; k++) begin
      tx_wr = 1; tx_wdata = 8'(k);
      tick(); idle();
    end
    sts_wr = 1; sts_wdata = 32'hFFFF_FFFF;
    tick(); idle();
    tick();
    chk("R7 above level", {31'd0, sts_q[4]}, 0);
    eng_tx_pop = 1; tick(); idle();
    eng_tx_pop = 1; tick(); idle();
    chk("R7 at level not yet", {31'd0, sts_q[4]}, 0);
    tick();
    chk("R7 tx request", {31'd0, sts_q[4]}, 1);
    eng_tx_pop = 1; tick(); tick(); idle();

    ien_wr = 1; ien_wdata = 32'hFFFF_FFFF;
    tick(); idle();
    chk("R10 enable bits", ien_q, 32'h1111);
    chk("R10 irq on", {31'd0, irq}, 1);
    ien_wr = 1; ien_wdata = 32'h0000_0100;
    tick(); idle();
    chk("R10 irq masked", {31'd0, irq}, 0);

    for (int k = 0; k < DEPTH; k++) begin
      eng_rx_push = 1; eng_rx_data = 8'(k);
      tick(); idle();
    end
    chk("R3 full count", {24'd0, occ_q[7:0]}, DEPTH);
    chk("R3 no flag yet", {31'd0, sts_q[8]}, 0);
    eng_rx_push = 1; eng_rx_data = 8'hEE;
    tick(); idle();
    chk("R3 overflow flag", {31'd0, sts_q[8]}, 1);
    chk("R3 count held", {24'd0, occ_q[7:0]}, DEPTH);
    chk("R10 irq overflow", {31'd0, irq}, 1);
    chk("R2 rx first", {24'd0, rx_rdata}, 0);
    rx_rd = 1;
    repeat (DEPTH - 1) tick();
    idle();
    chk("R3 last byte kept", {24'd0, rx_rdata}, DEPTH - 1);
    rx_rd = 1; tick(); idle();
    chk("R2 rx drained", {24'd0, occ_q[7:0]}, 0);

    for (int k = 0; k < DEPTH; k++) begin
      tx_wr = 1; tx_wdata = 8'(k + 8'h40);
      tick(); idle();
    end
    chk("R1 tx full count", {24'd0, occ_q[23:16]}, DEPTH);
    tx_wr = 1; tx_wdata = 8'hEE;
    tick(); idle();
    chk("R4 count held", {24'd0, occ_q[23:16]}, DEPTH);
    eng_tx_pop = 1;
    repeat (DEPTH - 1) tick();
    idle();
    chk("R4 contents unchanged", {24'd0, eng_tx_data}, 32'h7F);
    eng_tx_pop = 1; tick(); idle();
    chk("R1 tx empty", {31'd0, eng_tx_valid}, 0);

    xfer_done = 1; sts_wr = 1; sts_wdata = 32'h1000;
    tick(); idle();
    chk("R11 set wins", {31'd0, sts_q[12]}, 1);
    sts_wr = 1; sts_wdata = 32'h1000;
    tick(); idle();
    chk("R8 clear one", {31'd0, sts_q[12]}, 0);
    xfer_done = 1; tick(); idle();
    chk("R9 done flag", {31'd0, sts_q[12]}, 1);
    sts_wr = 1; sts_wdata = 32'h0100;
    tick(); idle();
    chk("R8 selective cleared", {31'd0, sts_q[8]}, 0);
    chk("R8 selective kept", {31'd0, sts_q[12]}, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule